// File: doc/BRIEF.md
# Scalar Accumulator ALU with Carry and Zero Flags

This block is the arithmetic heart of a small scalar accumulator core. It takes one 32-bit instruction word together with the current contents of the three scalar registers (A, X, Y) and the two status flags (carry, zero). It picks two operands from the instruction's source fields and performs one of sixteen operation codes. It then returns the result, a one-hot write strobe for the destination register and the next values of both flags. The block is purely combinational. The surrounding core owns the registers and flags and captures the outputs on its own clock edge.

The first operand field can select a hard zero or a register. The second operand field can select a zero-extended 16-bit immediate or a register. This lets a single encoding express move, load-immediate, compare and clear as special cases of ordinary arithmetic. Rotates run through the carry flag, and the add and subtract operations have with-carry variants, so multi-word arithmetic and shifts can be chained across several instructions. The multiply code is optional; with the multiplier left out it behaves as a no-operation.

Top module: `scalar_acc_alu`

## Requirements
- R1: The block acts only when instruction bits [31:30] equal 01. For any other value, no destination strobe is raised, `flag_we` is 0, and the flag outputs equal the flag inputs.
- R2: The first source field, bits [23:22], selects the first operand: 00 gives the constant zero, 01 gives A, 10 gives X and 11 gives Y.
- R3: The second source field, bits [21:20], selects the second operand: 00 gives instruction bits [15:0] zero-extended to 32 bits, 01 gives A, 10 gives X and 11 gives Y.
- R4: The destination field, bits [25:24], raises at most one strobe: 00 none, 01 `wr_a`, 10 `wr_x`, 11 `wr_y`. A strobe is raised only for an operation that produces a result.
- R5: The operation field is bits [29:26]. ADD (0000) yields s+t and ADC (0001) yields s+t+carry_in. In both cases the new carry is the carry out of bit 31.
- R6: SUB (0010) yields s-t and SBC (0011) yields s-t-carry_in. In both cases the new carry is 1 exactly when a borrow occurs, that is, when s is less than t plus the subtracted carry.
- R7: INC (0100) yields s+1 and DEC (0110) yields s-1. Both ignore the second operand. The new carry is the carry out of INC or the borrow of DEC.
- R8: AND (1000), OR (1001) and XOR (1010) combine s and t bitwise and leave the carry unchanged.
- R9: LSL (1100) shifts s left by one and LSR (1110) shifts s right by one. Each inserts a 0, and the bit shifted out becomes the new carry.
- R10: ROL (1101) and ROR (1111) shift s by one, inserting carry_in at the vacated end. The bit shifted out becomes the new carry.
- R11: Whenever `flag_we` is 1, `zero_out` is 1 exactly when the 32-bit result is zero.
- R12: With the multiplier left out (the default), code 1011 and the unassigned codes 0101 and 0111 raise no strobe and set `flag_we` to 0.
- R13: Whenever `flag_we` is 0, `carry_out` equals `carry_in` and `zero_out` equals `zero_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word holding class, operation, register fields and immediate |
| reg_a | input | 32 | Current value of register A |
| reg_x | input | 32 | Current value of register X |
| reg_y | input | 32 | Current value of register Y |
| carry_in | input | 1 | Current carry flag |
| zero_in | input | 1 | Current zero flag |
| result | output | 32 | Operation result |
| wr_a | output | 1 | Write strobe for register A |
| wr_x | output | 1 | Write strobe for register X |
| wr_y | output | 1 | Write strobe for register Y |
| flag_we | output | 1 | The flags take new values this instruction |
| carry_out | output | 1 | Next carry flag |
| zero_out | output | 1 | Next zero flag |

## Verification
The assertions sample combinational outputs, so they assume every input is driven to a known value whenever they are evaluated. They make no assumption about which instruction class or operation code is present. The stimulus drives all inputs together on the falling clock edge and never leaves an input undriven, including while reset is held. It sweeps every operation code, every select code and every instruction class, so each guarded property is both triggered and left untriggered.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_ADC  = 4'b0001,
    OP_SUB  = 4'b0010,
    OP_SBC  = 4'b0011,
    OP_INC  = 4'b0100,
    OP_RSV5 = 4'b0101,
    OP_DEC  = 4'b0110,
    OP_RSV7 = 4'b0111,
    OP_AND  = 4'b1000,
    OP_OR   = 4'b1001,
    OP_XOR  = 4'b1010,
    OP_MUL  = 4'b1011,
    OP_LSL  = 4'b1100,
    OP_ROL  = 4'b1101,
    OP_LSR  = 4'b1110,
    OP_ROR  = 4'b1111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_CTRL  = 2'b00,
    CLS_ALU   = 2'b01,
    CLS_MEM   = 2'b10,
    CLS_OTHER = 2'b11
  } instr_cls_e;

  typedef struct packed {
    logic carry;
    logic zero;
  } flags_t;

  localparam int unsigned CLS_HI  = 31;
  localparam int unsigned OP_HI   = 29;
  localparam int unsigned DST_HI  = 25;
  localparam int unsigned SRC1_HI = 23;
  localparam int unsigned SRC2_HI = 21;

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int unsigned W        = 32,
  parameter int unsigned IMM_W    = 16,
  parameter bit          USE_IMM  = 1'b0
) (
  input  logic [1:0]       sel,
  input  logic [IMM_W-1:0] imm,
  input  logic [W-1:0]     ra,
  input  logic [W-1:0]     rx,
  input  logic [W-1:0]     ry,
  output logic [W-1:0]     opnd
);

  localparam int unsigned PAD_W = W - IMM_W;

  logic [W-1:0] code0_val;

  generate
    if (USE_IMM) begin : g_imm
      assign code0_val = {{PAD_W{1'b0}}, imm};
    end else begin : g_zero
      logic unused_imm;
      assign unused_imm = ^imm;
      assign code0_val  = '0;
    end
  endgenerate

  always_comb begin
    case (sel)
      2'b00:   opnd = code0_val;
      2'b01:   opnd = ra;
      2'b10:   opnd = rx;
      default: opnd = ry;
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import acc_alu_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter bit          HAS_MUL = 1'b0
) (
  input  alu_op_e      op,
  input  logic [W-1:0] s,
  input  logic [W-1:0] t,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         zout,
  output logic         upd,
  output logic         wr_ok
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W:0] add_wc(input logic [W-1:0] x, input logic [W-1:0] y,
                                        input logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  function automatic logic [W:0] sub_wb(input logic [W-1:0] x, input logic [W-1:0] y,
                                        input logic bi);
    return {1'b0, x} - {1'b0, y} - {{W{1'b0}}, bi};
  endfunction

  function automatic logic [W:0] shl_in(input logic [W-1:0] x, input logic fill);
    return {x, fill};
  endfunction

  function automatic logic [W:0] shr_in(input logic [W-1:0] x, input logic fill);
    return {x[0], fill, x[W-1:1]};
  endfunction

  logic [W:0]   sum_full;
  logic [W:0]   diff_full;
  logic [W:0]   shl_full;
  logic [W:0]   shr_full;
  logic         add_cin;
  logic         sub_bin;
  logic [W-1:0] add_rhs;
  logic         shift_fill;
  logic [W-1:0] mul_lo;

  always_comb begin
    add_cin = (op == OP_ADC) ? cin : 1'b0;
    sub_bin = (op == OP_SBC) ? cin : 1'b0;
    add_rhs = (op == OP_INC || op == OP_DEC) ? ONE : t;
    shift_fill = (op == OP_ROL || op == OP_ROR) ? cin : 1'b0;
  end

  assign sum_full  = add_wc(s, add_rhs, add_cin);
  assign diff_full = sub_wb(s, add_rhs, sub_bin);
  assign shl_full  = shl_in(s, shift_fill);
  assign shr_full  = shr_in(s, shift_fill);

  generate
    if (HAS_MUL) begin : g_mul
      assign mul_lo = s * t;
    end else begin : g_nomul
      assign mul_lo = '0;
    end
  endgenerate

  always_comb begin
    res   = '0;
    cout  = cin;
    upd   = 1'b1;
    wr_ok = 1'b1;
    case (op)
      OP_ADD, OP_ADC, OP_INC: begin
        res  = sum_full[W-1:0];
        cout = sum_full[W];
      end
      OP_SUB, OP_SBC, OP_DEC: begin
        res  = diff_full[W-1:0];
        cout = diff_full[W];
      end
      OP_AND: res = s & t;
      OP_OR:  res = s | t;
      OP_XOR: res = s ^ t;
      OP_LSL, OP_ROL: begin
        res  = shl_full[W-1:0];
        cout = shl_full[W];
      end
      OP_LSR, OP_ROR: begin
        res  = shr_full[W-1:0];
        cout = shr_full[W];
      end
      OP_MUL: begin
        res   = mul_lo;
        upd   = HAS_MUL;
        wr_ok = HAS_MUL;
      end
      default: begin
        upd   = 1'b0;
        wr_ok = 1'b0;
      end
    endcase
  end

  assign zout = (res == '0);

endmodule

// File: rtl/alu_dest_dec.sv
module alu_dest_dec #(
  parameter int unsigned N_REG = 3
) (
  input  logic                      en,
  input  logic [$clog2(N_REG+1)-1:0] sel,
  output logic [N_REG-1:0]          strobe
);

  generate
    for (genvar i = 0; i < N_REG; i++) begin : g_strobe
      assign strobe[i] = en && (sel == ($clog2(N_REG+1))'(i + 1));
    end
  endgenerate

endmodule

// File: rtl/scalar_acc_alu.sv
module scalar_acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IMM_W   = 16,
  parameter bit          HAS_MUL = 1'b0
) (
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_x,
  input  logic [DATA_W-1:0] reg_y,
  input  logic              carry_in,
  input  logic              zero_in,
  output logic [DATA_W-1:0] result,
  output logic              wr_a,
  output logic              wr_x,
  output logic              wr_y,
  output logic              flag_we,
  output logic              carry_out,
  output logic              zero_out
);

  localparam int unsigned N_REG = 3;

  instr_cls_e  cls;
  alu_op_e     core_op;
  logic [1:0]  dst_sel;
  logic [1:0]  src1_sel;
  logic [1:0]  src2_sel;
  logic [IMM_W-1:0] imm;
  logic        is_alu;
  logic        unused_bits;

  assign cls      = instr_cls_e'(instr[CLS_HI -: 2]);
  assign core_op  = alu_op_e'(instr[OP_HI -: 4]);
  assign dst_sel  = instr[DST_HI -: 2];
  assign src1_sel = instr[SRC1_HI -: 2];
  assign src2_sel = instr[SRC2_HI -: 2];
  assign imm      = instr[IMM_W-1:0];
  assign is_alu   = (cls == CLS_ALU);
  assign unused_bits = ^instr[19:IMM_W];

  logic [DATA_W-1:0] s_val;
  logic [DATA_W-1:0] t_val;
  logic [DATA_W-1:0] core_res;
  logic              core_c;
  logic              core_z;
  logic              core_upd;
  logic              core_wr;
  logic [N_REG-1:0]  strobes;

  alu_operand_sel #(.W(DATA_W), .IMM_W(IMM_W), .USE_IMM(1'b0)) u_src1 (
    .sel(src1_sel), .imm(imm), .ra(reg_a), .rx(reg_x), .ry(reg_y), .opnd(s_val)
  );

  alu_operand_sel #(.W(DATA_W), .IMM_W(IMM_W), .USE_IMM(1'b1)) u_src2 (
    .sel(src2_sel), .imm(imm), .ra(reg_a), .rx(reg_x), .ry(reg_y), .opnd(t_val)
  );

  alu_core #(.W(DATA_W), .HAS_MUL(HAS_MUL)) u_core (
    .op(core_op), .s(s_val), .t(t_val), .cin(carry_in),
    .res(core_res), .cout(core_c), .zout(core_z), .upd(core_upd), .wr_ok(core_wr)
  );

  alu_dest_dec #(.N_REG(N_REG)) u_dest (
    .en(is_alu && core_wr), .sel(dst_sel), .strobe(strobes)
  );

  assign result    = core_res;
  assign wr_a      = strobes[0];
  assign wr_x      = strobes[1];
  assign wr_y      = strobes[2];
  assign flag_we   = is_alu && core_upd;
  assign carry_out = flag_we ? core_c : carry_in;
  assign zero_out  = flag_we ? core_z : zero_in;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int unsigned W       = 32,
  parameter bit          HAS_MUL = 1'b0
) (
  input logic [31:0]  instr,
  input logic [W-1:0] result,
  input logic         wr_a,
  input logic         wr_x,
  input logic         wr_y,
  input logic         flag_we,
  input logic         carry_in,
  input logic         zero_in,
  input logic         carry_out,
  input logic         zero_out
);

  logic [3:0] op_f;
  assign op_f = instr[29:26];

  always_comb begin
    if (instr[31:30] != 2'b01)
      a_r1_idle_class: assert (!flag_we && !wr_a && !wr_x && !wr_y);
    a_r4_strobe_onehot: assert ($onehot0({wr_a, wr_x, wr_y}));
    if (instr[25:24] == 2'b00)
      a_r4_no_dest: assert (!wr_a && !wr_x && !wr_y);
    if (flag_we && (op_f == 4'b1000 || op_f == 4'b1001 || op_f == 4'b1010))
      a_r8_logic_keeps_carry: assert (carry_out == carry_in);
    if (flag_we && op_f == 4'b1100)
      a_r9_lsl_fill_zero: assert (result[0] == 1'b0);
    if (flag_we && op_f == 4'b1110)
      a_r9_lsr_fill_zero: assert (result[W-1] == 1'b0);
    if (flag_we)
      a_r11_zero_matches: assert (zero_out == (result == '0));
    if (op_f == 4'b0101 || op_f == 4'b0111 || (op_f == 4'b1011 && !HAS_MUL))
      a_r12_inert_codes: assert (!flag_we && !wr_a && !wr_x && !wr_y);
    if (!flag_we)
      a_r13_flags_pass: assert (carry_out == carry_in && zero_out == zero_in);
  end

endmodule

bind scalar_acc_alu acc_alu_chk #(.W(DATA_W), .HAS_MUL(HAS_MUL)) u_chk (
  .instr(instr), .result(result), .wr_a(wr_a), .wr_x(wr_x), .wr_y(wr_y),
  .flag_we(flag_we), .carry_in(carry_in), .zero_in(zero_in),
  .carry_out(carry_out), .zero_out(zero_out)
);

// File: tb/tb_scalar_acc_alu.sv
module tb_scalar_acc_alu;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] instr = '0;
  logic [31:0] reg_a = '0, reg_x = '0, reg_y = '0;
  logic        carry_in = 1'b0, zero_in = 1'b0;
  logic [31:0] result;
  logic        wr_a, wr_x, wr_y, flag_we, carry_out, zero_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  scalar_acc_alu dut (
    .instr(instr), .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y),
    .carry_in(carry_in), .zero_in(zero_in), .result(result),
    .wr_a(wr_a), .wr_x(wr_x), .wr_y(wr_y), .flag_we(flag_we),
    .carry_out(carry_out), .zero_out(zero_out)
  );

  function automatic string req_of(input logic [1:0] cls, input logic [3:0] op);
    if (cls != 2'b01) return "R1";
    case (op)
      4'd0, 4'd1:           return "R5";
      4'd2, 4'd3:           return "R6";
      4'd4, 4'd6:           return "R7";
      4'd8, 4'd9, 4'd10:    return "R8";
      4'd12, 4'd14:         return "R9";
      4'd13, 4'd15:         return "R10";
      default:              return "R12";
    endcase
  endfunction

  function automatic logic [31:0] pick(input logic [1:0] sel, input logic [31:0] code0);
    case (sel)
      2'd0: return code0;
      2'd1: return reg_a;
      2'd2: return reg_x;
      default: return reg_y;
    endcase
  endfunction

  task automatic check_now(input string tag);
    logic [1:0]  cls;
    logic [3:0]  op;
    logic [31:0] s, t, e_res;
    longint      wide;
    logic        e_c, e_z, e_upd, e_wr;
    logic [2:0]  e_str, got_str;
    cls = instr[31:30];
    op  = instr[29:26];
    s   = pick(instr[23:22], 32'd0);
    t   = pick(instr[21:20], {16'd0, instr[15:0]});
    e_res = 32'd0; e_c = carry_in; e_upd = 1'b1; e_wr = 1'b1;
    case (op)
      4'd0, 4'd1: begin
        wide = longint'(s) + longint'(t) + ((op == 4'd1) ? longint'(carry_in) : 64'sd0);
        e_res = wide[31:0]; e_c = (wide >= 64'sh1_0000_0000);
      end
      4'd2, 4'd3: begin
        wide = longint'(t) + ((op == 4'd3) ? longint'(carry_in) : 64'sd0);
        e_c  = (longint'(s) < wide);
        e_res = s - wide[31:0];
      end
      4'd4: begin e_res = s + 32'd1; e_c = (s == 32'hFFFF_FFFF); end
      4'd6: begin e_res = s - 32'd1; e_c = (s == 32'd0); end
      4'd8:  e_res = s & t;
      4'd9:  e_res = s | t;
      4'd10: e_res = s ^ t;
      4'd12: begin e_res = s * 32'd2; e_c = s[31]; end
      4'd13: begin e_res = s * 32'd2 + {31'd0, carry_in}; e_c = s[31]; end
      4'd14: begin e_res = s / 32'd2; e_c = s[0]; end
      4'd15: begin e_res = s / 32'd2 + (carry_in ? 32'h8000_0000 : 32'd0); e_c = s[0]; end
      default: begin e_upd = 1'b0; e_wr = 1'b0; end
    endcase
    if (cls != 2'b01) begin e_upd = 1'b0; e_wr = 1'b0; end
    e_z = e_upd ? (e_res == 32'd0) : zero_in;
    if (!e_upd) e_c = carry_in;
    e_str = 3'b000;
    if (e_wr && instr[25:24] != 2'b00) e_str[instr[25:24] - 2'd1] = 1'b1;
    got_str = {wr_y, wr_x, wr_a};
    n_checks++;
    if (flag_we !== e_upd || carry_out !== e_c || zero_out !== e_z || got_str !== e_str ||
        (e_wr && result !== e_res)) begin
      n_fail++;
      $display("FAIL %s/%s instr=%h: res=%h c=%b z=%b fwe=%b str=%b ; exp res=%h c=%b z=%b fwe=%b str=%b",
               tag, req_of(cls, op), instr, result, carry_out, zero_out, flag_we, got_str,
               e_res, e_c, e_z, e_upd, e_str);
    end
  endtask

  task automatic drive(input logic [31:0] ins, input logic ci, input logic zi, input string tag);
    @(negedge clk);
    instr = ins; carry_in = ci; zero_in = zi;
    #1;
    check_now(tag);
  endtask

  function automatic logic [31:0] mk(input logic [1:0] cls, input logic [3:0] op,
                                     input logic [1:0] d, input logic [1:0] s,
                                     input logic [1:0] t, input logic [15:0] imm);
    return {cls, op, d, s, t, 4'b0000, imm};
  endfunction

  logic [31:0] vals [6] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero word is a control-class no-op (R1, R13)
    drive(32'h0, 1'b1, 1'b0, "reset R1 R13");

    // every operation code over operand corner values (R5..R12, R11, R13)
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int c = 0; c < 2; c++) begin
            reg_a = vals[i]; reg_x = vals[j]; reg_y = 32'hDEAD_BEEF;
            drive(mk(2'b01, 4'(op), 2'((i + j + c) % 4), 2'b01, 2'b10, 16'h0),
                  1'(c), ~1'(c), "ops R11 R13");
          end

    // operand and destination selects, immediate zero-extension (R2 R3 R4)
    reg_a = 32'h0000_0100; reg_x = 32'h0000_0020; reg_y = 32'h0000_0003;
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++)
        for (int d = 0; d < 4; d++) begin
          drive(mk(2'b01, 4'b0000, 2'(d), 2'(s), 2'(t), 16'hABCD), 1'b0, 1'b1, "sel R2 R3 R4");
          drive(mk(2'b01, 4'b1001, 2'(d), 2'(s), 2'(t), 16'h8001), 1'b1, 1'b0, "sel R2 R3 R4");
        end

    // non-ALU classes have no effect (R1)
    for (int cl = 0; cl < 4; cl++)
      for (int op = 0; op < 16; op += 5)
        drive(mk(2'(cl), 4'(op), 2'b01, 2'b01, 2'b11, 16'h0), 1'b1, 1'b1, "class R1");

    // clear via zero source and zero immediate sets zero flag (R11)
    drive(mk(2'b01, 4'b0000, 2'b11, 2'b00, 2'b00, 16'h0), 1'b0, 1'b0, "clear R11");

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete (expected completion)");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule